// File: doc/BRIEF.md
# LCD Palette and Frame Load Sequencer

This block is the control and status core of an LCD refresh engine. It fetches 32-bit words over a simple request/acknowledge read port. It can load a colour palette, a frame, or a palette followed by frames. The first palette word carries a depth code in its low half. That code tells the sequencer how many palette entries to write: a short table for 12/16-bit pixels or a 256-entry table for 8-bit pixels. Each fetched palette word yields two 16-bit entries, which go out on a palette-write strobe with an entry address. The colour lookup itself lies outside the block. Each 12-bit colour keeps red in bits 11:8, green in 7:4 and blue in 3:0.

Once started, frame fetching loops over the frame buffer for as long as the controller stays enabled. Clearing the enable bit is graceful: the frame in progress is completed before the sequencer stops and raises the done flag. A status register gathers completion, palette-loaded, underrun, sync-lost, vertical-sync, line and AC-bias events. Each status bit has its own clearing rule, and a single interrupt line reports the status bits whose mask bits are set.

Top module: `lcd_load_seq`

## Requirements
- R1: After reset the control register, status register, interrupt, fetch request and palette strobe are all zero.
- R2: Control bits 21:20 select the load type: 1 loads the palette only, 0 loads the palette and then frames, 2 or 3 load frames only. Palette word k is read at palette base + k, and frame word j at frame base + j.
- R3: In palette-only mode no fetch is requested after the last palette word, for as long as the controller remains enabled.
- R4: Bits 15:12 of palette word 0 hold the depth code. Code 0x3 selects 256 entries and a 129-word fetch; any other code selects 16 entries and a 9-word fetch. Status bit 2 (palette loaded) sets after the last palette word.
- R5: Entry 2k takes bits 15:0 of palette word k and entry 2k+1 takes bits 31:16. The palette address equals the entry number, and no entry at or beyond the selected count is written.
- R6: When enable (control bit 0) is written to 0, the frame in progress finishes. Status bit 0 (done) then sets and no further fetch is made. From idle or from the palette-only hold, done sets without any fetch.
- R7: Done stays set until enable is written from 0 to 1, which clears it.
- R8: Underrun (bit 5) and sync-lost (bit 6) set on their input pulses while enabled. Status writes do not affect them, and writing enable from 1 to 0 clears them. Palette loaded (bit 2) clears on a status write of 1 only in palette-only mode; otherwise only the disable write clears it.
- R9: In frame modes, after the last word of a frame the fetch restarts at frame base while enabled.
- R10: The interrupt output is high whenever some status bit n is set together with control mask bit 8+n.
- R11: Vertical sync (bit 1), AC-bias count (bit 3) and line (bit 4) set on their input pulses while enabled, and clear when a 1 is written to that bit of the status register.
- R12: A fetch request stays asserted with a stable address until acknowledged, and no palette write occurs while a fetch request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWe | input | 1 | Control register write strobe |
| ctlWdata | input | 32 | Control register write value |
| stsWe | input | 1 | Status register write strobe (write 1 to clear) |
| stsWdata | input | 7 | Status register write value |
| ctlRd | output | 32 | Control register contents |
| stsRd | output | 7 | Status register contents |
| irq | output | 1 | Masked interrupt |
| evVsync | input | 1 | Vertical sync event pulse |
| evLine | input | 1 | Line event pulse |
| evAcb | input | 1 | AC-bias count event pulse |
| evUnderrun | input | 1 | Pixel FIFO underrun pulse |
| evSyncLost | input | 1 | Sync lost pulse |
| palBase | input | 16 | Palette buffer word address |
| frameBase | input | 16 | Frame buffer word address |
| frameLen | input | 12 | Words per frame (at least 1) |
| dmaReq | output | 1 | Word fetch request |
| dmaAddr | output | 16 | Word fetch address |
| dmaAck | input | 1 | Fetch acknowledge, data valid |
| dmaData | input | 32 | Fetched word |
| palWe | output | 1 | Palette entry write strobe |
| palAddr | output | 8 | Palette entry address |
| palData | output | 16 | Palette entry value |

## Verification
The checks assume that the memory side raises dmaAck only while dmaReq is high and holds dmaData valid with it. They also assume that frameLen is non-zero and stable during a load, and that palBase stays fixed while palette words are fetched. The bench's memory model enforces this: it acknowledges only pending requests, with a wait of one or two cycles, so acknowledges never come back to back. The bench changes base addresses and the frame length only while the sequencer is idle, and it raises event inputs as single-cycle pulses.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

  localparam int ST_W         = 7;
  localparam int ST_DONE      = 0;
  localparam int ST_VSYNC     = 1;
  localparam int ST_LOADED    = 2;
  localparam int ST_ACB       = 3;
  localparam int ST_LINE      = 4;
  localparam int ST_UNDERRUN  = 5;
  localparam int ST_SYNCLOST  = 6;

  localparam int CTL_EN       = 0;
  localparam int CTL_MASK_LSB = 8;
  localparam int CTL_MODE_LSB = 20;

  localparam logic [3:0] DEPTH_CODE_LARGE = 4'h3;

  localparam logic [ST_W-1:0] W1C_ALWAYS =
    ST_W'((1 << ST_VSYNC) | (1 << ST_ACB) | (1 << ST_LINE));
  localparam logic [ST_W-1:0] CLR_ON_DISABLE =
    ST_W'((1 << ST_LOADED) | (1 << ST_UNDERRUN) | (1 << ST_SYNCLOST));
  localparam logic [ST_W-1:0] LOADED_BIT = ST_W'(1 << ST_LOADED);

  typedef enum logic [1:0] {
    LM_BOTH  = 2'd0,
    LM_PAL   = 2'd1,
    LM_FRAME = 2'd2,
    LM_RSVD  = 2'd3
  } loadMode_e;

  typedef struct packed {
    logic selPal;
    logic startPal;
    logic startFrm;
    logic latchWord;
    logic wrLo;
    logic wrHi;
    logic advPal;
    logic advFrm;
  } seqCmd_t;

endpackage

// File: rtl/lcdseq_regs.sv
module lcdseq_regs
  import lcdseq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            ctlWe,
  input  logic [31:0]     ctlWdata,
  input  logic            stsWe,
  input  logic [ST_W-1:0] stsWdata,
  input  logic            evVsync,
  input  logic            evLine,
  input  logic            evAcb,
  input  logic            evUnderrun,
  input  logic            evSyncLost,
  input  logic            setDone,
  input  logic            setLoaded,
  output logic            enable,
  output loadMode_e       loadMode,
  output logic [31:0]     ctlRd,
  output logic [ST_W-1:0] stsRd,
  output logic            irq
);

  logic [31:0]     ctlReg;
  logic [ST_W-1:0] sts, stsNxt, setVec, w1cAllow, clrVec;
  logic            enRise, enFall;

  assign enable   = ctlReg[CTL_EN];
  assign loadMode = loadMode_e'(ctlReg[CTL_MODE_LSB +: 2]);
  assign enRise   = ctlWe & ctlWdata[CTL_EN] & ~enable;
  assign enFall   = ctlWe & ~ctlWdata[CTL_EN] & enable;

  always_comb begin
    setVec              = '0;
    setVec[ST_DONE]     = setDone;
    setVec[ST_LOADED]   = setLoaded;
    setVec[ST_VSYNC]    = evVsync & enable;
    setVec[ST_LINE]     = evLine & enable;
    setVec[ST_ACB]      = evAcb & enable;
    setVec[ST_UNDERRUN] = evUnderrun & enable;
    setVec[ST_SYNCLOST] = evSyncLost & enable;

    w1cAllow = W1C_ALWAYS | ((loadMode == LM_PAL) ? LOADED_BIT : '0);
    clrVec   = stsWe ? (stsWdata & w1cAllow) : '0;

    stsNxt = (sts & ~clrVec) | setVec;
    if (enRise) stsNxt[ST_DONE] = 1'b0;
    if (enFall) stsNxt = stsNxt & ~CLR_ON_DISABLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg <= '0;
      sts    <= '0;
    end else begin
      if (ctlWe) ctlReg <= ctlWdata;
      sts <= stsNxt;
    end
  end

  assign ctlRd = ctlReg;
  assign stsRd = sts;
  assign irq   = |(sts & ctlReg[CTL_MASK_LSB +: ST_W]);

  // R7: an enable write from 0 to 1 leaves done clear
  a_r7_done_cleared_on_enable: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWe && ctlWdata[CTL_EN] && !enable) |=> !stsRd[ST_DONE]);

  // R8: underrun survives everything except a disable write
  a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (stsRd[ST_UNDERRUN] && !(ctlWe && !ctlWdata[CTL_EN])) |=> stsRd[ST_UNDERRUN]);

  // R6: done only appears while the controller is off
  a_r6_done_when_off: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsRd[ST_DONE]) |-> !enable);

endmodule

// File: rtl/lcdseq_ctrl.sv
module lcdseq_ctrl
  import lcdseq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  loadMode_e loadMode,
  input  logic      dmaAck,
  input  logic      palLast,
  input  logic      frmLast,
  output logic      dmaReq,
  output seqCmd_t   cmd,
  output logic      setDone,
  output logic      setLoaded
);

  typedef enum logic [2:0] {
    S_IDLE, S_PAL_REQ, S_PAL_LO, S_PAL_HI, S_FRM_REQ, S_HOLD
  } seqState_e;

  seqState_e state, nxt;

  always_comb begin
    nxt       = state;
    cmd       = '0;
    dmaReq    = 1'b0;
    setDone   = 1'b0;
    setLoaded = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (enable) begin
          if (loadMode == LM_PAL || loadMode == LM_BOTH) begin
            cmd.startPal = 1'b1;
            nxt          = S_PAL_REQ;
          end else begin
            cmd.startFrm = 1'b1;
            nxt          = S_FRM_REQ;
          end
        end
      end
      S_PAL_REQ: begin
        dmaReq     = 1'b1;
        cmd.selPal = 1'b1;
        if (dmaAck) begin
          cmd.latchWord = 1'b1;
          nxt           = S_PAL_LO;
        end
      end
      S_PAL_LO: begin
        cmd.wrLo = 1'b1;
        nxt      = S_PAL_HI;
      end
      S_PAL_HI: begin
        cmd.wrHi = 1'b1;
        if (palLast) begin
          setLoaded = 1'b1;
          if (loadMode == LM_PAL) begin
            nxt = S_HOLD;
          end else if (enable) begin
            cmd.startFrm = 1'b1;
            nxt          = S_FRM_REQ;
          end else begin
            setDone = 1'b1;
            nxt     = S_IDLE;
          end
        end else begin
          cmd.advPal = 1'b1;
          if (enable) begin
            nxt = S_PAL_REQ;
          end else begin
            setDone = 1'b1;
            nxt     = S_IDLE;
          end
        end
      end
      S_FRM_REQ: begin
        dmaReq = 1'b1;
        if (dmaAck) begin
          if (frmLast) begin
            cmd.startFrm = 1'b1;
            if (!enable) begin
              setDone = 1'b1;
              nxt     = S_IDLE;
            end
          end else begin
            cmd.advFrm = 1'b1;
          end
        end
      end
      S_HOLD: begin
        if (!enable) begin
          setDone = 1'b1;
          nxt     = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

endmodule

// File: rtl/lcdseq_data.sv
module lcdseq_data
  import lcdseq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int FRAME_LEN_W = 12,
  parameter int PAL_LARGE   = 256,
  parameter int PAL_SMALL   = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqCmd_t                cmd,
  input  logic [31:0]            dmaData,
  input  logic [ADDR_W-1:0]      palBase,
  input  logic [ADDR_W-1:0]      frameBase,
  input  logic [FRAME_LEN_W-1:0] frameLen,
  output logic [ADDR_W-1:0]      dmaAddr,
  output logic                   palWe,
  output logic [$clog2(PAL_LARGE)-1:0] palAddr,
  output logic [15:0]            palData,
  output logic                   palLast,
  output logic                   frmLast
);

  localparam int WIDX_W = $clog2(PAL_LARGE / 2 + 1);
  localparam int ENT_W  = WIDX_W + 1;
  localparam int PAL_AW = $clog2(PAL_LARGE);

  logic [WIDX_W-1:0]      wordIdx;
  logic [FRAME_LEN_W-1:0] frmIdx;
  logic [31:0]            wordReg;
  logic                   largeTbl;
  logic [ENT_W-1:0]       entIdx, palLimit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordIdx  <= '0;
      frmIdx   <= '0;
      wordReg  <= '0;
      largeTbl <= 1'b0;
    end else begin
      if (cmd.startPal)    wordIdx <= '0;
      else if (cmd.advPal) wordIdx <= wordIdx + 1'b1;
      if (cmd.latchWord) begin
        wordReg <= dmaData;
        if (wordIdx == '0) largeTbl <= (dmaData[15:12] == DEPTH_CODE_LARGE);
      end
      if (cmd.startFrm)    frmIdx <= '0;
      else if (cmd.advFrm) frmIdx <= frmIdx + 1'b1;
    end
  end

  assign palLast  = wordIdx == (largeTbl ? WIDX_W'(PAL_LARGE / 2) : WIDX_W'(PAL_SMALL / 2));
  assign frmLast  = frmIdx == (frameLen - FRAME_LEN_W'(1));
  assign palLimit = largeTbl ? ENT_W'(PAL_LARGE) : ENT_W'(PAL_SMALL);
  assign entIdx   = {wordIdx, cmd.wrHi};
  assign palWe    = (cmd.wrLo | cmd.wrHi) && (entIdx < palLimit);
  assign palAddr  = entIdx[PAL_AW-1:0];
  assign palData  = cmd.wrHi ? wordReg[31:16] : wordReg[15:0];

  assign dmaAddr = cmd.selPal ? (palBase + ADDR_W'(wordIdx))
                              : (frameBase + ADDR_W'(frmIdx));

endmodule

// File: rtl/lcd_load_seq.sv
module lcd_load_seq
  import lcdseq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int FRAME_LEN_W = 12,
  parameter int PAL_LARGE   = 256,
  parameter int PAL_SMALL   = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ctlWe,
  input  logic [31:0]            ctlWdata,
  input  logic                   stsWe,
  input  logic [6:0]             stsWdata,
  output logic [31:0]            ctlRd,
  output logic [6:0]             stsRd,
  output logic                   irq,
  input  logic                   evVsync,
  input  logic                   evLine,
  input  logic                   evAcb,
  input  logic                   evUnderrun,
  input  logic                   evSyncLost,
  input  logic [ADDR_W-1:0]      palBase,
  input  logic [ADDR_W-1:0]      frameBase,
  input  logic [FRAME_LEN_W-1:0] frameLen,
  output logic                   dmaReq,
  output logic [ADDR_W-1:0]      dmaAddr,
  input  logic                   dmaAck,
  input  logic [31:0]            dmaData,
  output logic                   palWe,
  output logic [$clog2(PAL_LARGE)-1:0] palAddr,
  output logic [15:0]            palData
);

  seqCmd_t   cmd;
  logic      setDone, setLoaded, palLast, frmLast, enable;
  loadMode_e loadMode;

  lcdseq_regs u_regs (
    .clk, .rstN, .ctlWe, .ctlWdata, .stsWe, .stsWdata,
    .evVsync, .evLine, .evAcb, .evUnderrun, .evSyncLost,
    .setDone, .setLoaded, .enable, .loadMode, .ctlRd, .stsRd, .irq
  );

  lcdseq_ctrl u_ctrl (
    .clk, .rstN, .enable, .loadMode, .dmaAck, .palLast, .frmLast,
    .dmaReq, .cmd, .setDone, .setLoaded
  );

  lcdseq_data #(
    .ADDR_W(ADDR_W), .FRAME_LEN_W(FRAME_LEN_W),
    .PAL_LARGE(PAL_LARGE), .PAL_SMALL(PAL_SMALL)
  ) u_data (
    .clk, .rstN, .cmd, .dmaData, .palBase, .frameBase, .frameLen,
    .dmaAddr, .palWe, .palAddr, .palData, .palLast, .frmLast
  );

  // R12: a pending request keeps its address until acknowledged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !dmaAck) |=> (dmaReq && $stable(dmaAddr)));

  // R12: palette writes never overlap a pending fetch
  a_r12_pal_not_during_req: assert property (@(posedge clk) disable iff (!rstN)
    palWe |-> !dmaReq);

endmodule

// File: tb/sim_lcd_load_seq.sv
module sim_lcd_load_seq;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ctlWe, stsWe;
  logic [31:0] ctlWdata;
  logic [6:0]  stsWdata;
  logic [31:0] ctlRd;
  logic [6:0]  stsRd;
  logic        irq;
  logic        evVsync, evLine, evAcb, evUnderrun, evSyncLost;
  logic [15:0] palBase, frameBase;
  logic [11:0] frameLen;
  logic        dmaReq, dmaAck;
  logic [15:0] dmaAddr;
  logic [31:0] dmaData;
  logic        palWe;
  logic [7:0]  palAddr;
  logic [15:0] palData;

  int checks = 0;
  int errors = 0;
  int xferCount = 0;
  bit finished = 0;

  logic [15:0] expDma[$];
  logic [23:0] expPal[$];

  logic [15:0] curPalBase;
  logic [3:0]  curCode;

  lcd_load_seq u0 (
    .clk, .rstN, .ctlWe, .ctlWdata, .stsWe, .stsWdata, .ctlRd, .stsRd, .irq,
    .evVsync, .evLine, .evAcb, .evUnderrun, .evSyncLost,
    .palBase, .frameBase, .frameLen, .dmaReq, .dmaAddr, .dmaAck, .dmaData,
    .palWe, .palAddr, .palData
  );

  always #4 clk = ~clk;

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] memWord(input logic [15:0] a);
    logic [31:0] w;
    w = {a ^ 16'hc35a, a * 16'd7 + 16'h0101};
    if (a == curPalBase) w[15:12] = curCode;
    return w;
  endfunction

  task automatic pushPalette(input logic [15:0] base, input logic [3:0] code);
    int nWords, limit;
    logic [31:0] w;
    nWords = (code == 4'h3) ? 129 : 9;
    limit  = (code == 4'h3) ? 256 : 16;
    for (int k = 0; k < nWords; k++) begin
      expDma.push_back(base + 16'(k));
      w = memWord(base + 16'(k));
      if (2 * k < limit)     expPal.push_back({8'(2 * k), w[15:0]});
      if (2 * k + 1 < limit) expPal.push_back({8'(2 * k + 1), w[31:16]});
    end
  endtask

  task automatic pushFrames(input logic [15:0] base, input int len, input int count);
    for (int f = 0; f < count; f++)
      for (int j = 0; j < len; j++) expDma.push_back(base + 16'(j));
  endtask

  // memory model and monitor in one process
  initial begin
    int waitCnt;
    logic [15:0] e;
    logic [23:0] p;
    waitCnt = 0;
    dmaAck  = 1'b0;
    dmaData = '0;
    forever begin
      @(negedge clk);
      if (rstN && dmaReq && waitCnt == 0) begin
        dmaAck  = 1'b1;
        dmaData = memWord(dmaAddr);
        waitCnt = dmaAddr[0] ? 2 : 1;
        xferCount++;
        if (expDma.size() == 0) begin
          checks++; errors++;
          $display("FAIL R3 unexpected fetch actual=%0h expected=none", dmaAddr);
        end else begin
          e = expDma.pop_front();
          checkEq("R2/R9 fetch address", 32'(dmaAddr), 32'(e));
        end
      end else begin
        dmaAck = 1'b0;
        if (waitCnt > 0) waitCnt--;
      end
      if (rstN && palWe) begin
        if (expPal.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 unexpected palette write actual=%0h expected=none", palAddr);
        end else begin
          p = expPal.pop_front();
          checkEq("R5 palette write", 32'({palAddr, palData}), 32'(p));
        end
      end
    end
  end

  task automatic ctlWrite(input logic [31:0] d);
    @(negedge clk); ctlWe = 1'b1; ctlWdata = d;
    @(negedge clk); ctlWe = 1'b0;
  endtask

  task automatic stsWrite(input logic [6:0] d);
    @(negedge clk); stsWe = 1'b1; stsWdata = d;
    @(negedge clk); stsWe = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: evVsync = 1'b1;
      1: evLine = 1'b1;
      2: evAcb = 1'b1;
      3: evUnderrun = 1'b1;
      default: evSyncLost = 1'b1;
    endcase
    @(negedge clk);
    evVsync = 1'b0; evLine = 1'b0; evAcb = 1'b0; evUnderrun = 1'b0; evSyncLost = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 3000 && !stsRd[0]; i++) @(negedge clk);
  endtask

  task automatic waitXfer(input int n);
    while (xferCount < n) @(posedge clk);
  endtask

  task automatic finish();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish();
    end
  end

  initial begin
    int s;
    rstN = 1'b0; ctlWe = 1'b0; stsWe = 1'b0; ctlWdata = '0; stsWdata = '0;
    evVsync = 0; evLine = 0; evAcb = 0; evUnderrun = 0; evSyncLost = 0;
    palBase = 16'h1000; frameBase = 16'h2000; frameLen = 12'd5;
    curPalBase = 16'h1000; curCode = 4'h4;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkEq("R1 control", ctlRd, 32'h0);
    checkEq("R1 status", 32'(stsRd), 32'h0);
    checkEq("R1 irq", 32'(irq), 32'h0);
    checkEq("R1 request", 32'(dmaReq), 32'h0);
    checkEq("R1 palette strobe", 32'(palWe), 32'h0);

    // palette-only, short table (code 0x4), line interrupt unmasked
    pushPalette(16'h1000, 4'h4);
    ctlWrite(32'h1 | (32'd1 << 20) | (32'd1 << 12));
    while (expDma.size() != 0 || expPal.size() != 0) @(posedge clk);
    repeat (6) @(negedge clk);
    checkEq("R4 loaded flag after short palette", 32'(stsRd[2]), 32'h1);
    checkEq("R3 no request in hold", 32'(dmaReq), 32'h0);
    checkEq("R6 done clear while enabled", 32'(stsRd[0]), 32'h0);
    checkEq("R10 irq masked bits only", 32'(irq), 32'h0);
    pulse(0);
    checkEq("R11 vsync set", 32'(stsRd[1]), 32'h1);
    checkEq("R10 vsync masked no irq", 32'(irq), 32'h0);
    pulse(1);
    checkEq("R11 line set", 32'(stsRd[4]), 32'h1);
    checkEq("R10 line unmasked irq", 32'(irq), 32'h1);
    stsWrite(7'h12);
    checkEq("R11 vsync and line cleared", 32'(stsRd & 7'h12), 32'h0);
    checkEq("R10 irq drops", 32'(irq), 32'h0);
    pulse(2);
    checkEq("R11 acb set", 32'(stsRd[3]), 32'h1);
    stsWrite(7'h08);
    checkEq("R11 acb cleared", 32'(stsRd[3]), 32'h0);
    stsWrite(7'h04);
    checkEq("R8 loaded cleared by write in palette-only", 32'(stsRd[2]), 32'h0);
    pulse(3);
    pulse(4);
    checkEq("R8 underrun set", 32'(stsRd[5]), 32'h1);
    checkEq("R8 sync lost set", 32'(stsRd[6]), 32'h1);
    stsWrite(7'h60);
    checkEq("R8 underrun/sync-lost ignore writes", 32'(stsRd[6:5]), 32'h3);
    checkEq("R3 still no request", 32'(dmaReq), 32'h0);
    ctlWrite(32'h0);
    checkEq("R8 disable clears underrun/sync-lost", 32'(stsRd[6:5]), 32'h0);
    repeat (3) @(negedge clk);
    checkEq("R6 done after disable from hold", 32'(stsRd[0]), 32'h1);

    // frame-only, three frames, disable inside the last one
    s = xferCount;
    pushFrames(16'h2000, 5, 3);
    ctlWrite(32'h1 | (32'd2 << 20));
    checkEq("R7 done cleared by enable", 32'(stsRd[0]), 32'h0);
    waitXfer(s + 2 * 5 + 1);
    checkEq("R7 done stays clear while running", 32'(stsRd[0]), 32'h0);
    ctlWrite(32'h0);
    waitDone();
    checkEq("R6 done after final frame", 32'(stsRd[0]), 32'h1);
    checkEq("R9 all frame words fetched", expDma.size(), 32'h0);
    repeat (10) @(negedge clk);
    checkEq("R6 no fetch after done", 32'(dmaReq), 32'h0);

    // palette then frames, large table (code 0x3)
    curPalBase = 16'h1100; curCode = 4'h3; palBase = 16'h1100;
    s = xferCount;
    pushPalette(16'h1100, 4'h3);
    pushFrames(16'h2000, 5, 2);
    ctlWrite(32'h1);
    checkEq("R7 done cleared by second enable", 32'(stsRd[0]), 32'h0);
    waitXfer(s + 129 + 5 + 1);
    @(negedge clk);
    checkEq("R4 loaded flag after long palette", 32'(stsRd[2]), 32'h1);
    checkEq("R5 all 256 entries written", expPal.size(), 32'h0);
    stsWrite(7'h04);
    checkEq("R8 loaded ignores write in combined mode", 32'(stsRd[2]), 32'h1);
    ctlWrite(32'h0);
    checkEq("R8 disable clears loaded", 32'(stsRd[2]), 32'h0);
    waitDone();
    checkEq("R6 done after combined load", 32'(stsRd[0]), 32'h1);
    checkEq("R2 combined fetch order complete", expDma.size(), 32'h0);
    repeat (10) @(negedge clk);
    checkEq("R6 idle after combined load", 32'(dmaReq), 32'h0);

    finish();
  end

endmodule